// File: doc/BRIEF.md
# Wiper Initial-Value Store and Recall Sequencer

This block owns the wiper code of a digitally controlled potentiometer and the single persistent byte that fixes the wiper position after power comes up. Two digital supply-good flags, one for the negative rail and one for the positive rail, pass through a small synchronizer. The sequencer then qualifies them in a fixed order: first the negative rail, then the positive rail. Until both are good the wiper is pinned at mid-scale. Once both are good it issues one read on a simple external memory port, loads the returned code into the wiper, waits a settle interval, and only then tells the bus interface that it is ready.

When it is ready, the bus interface may write the wiper in one of two ways. A volatile-only write moves the wiper and nothing else. A persistent write moves the wiper and also starts a self-timed store. That store issues one write pulse to the memory port and keeps the block busy for a fixed number of clock cycles, and the bus interface is locked out for that time. If either supply flag falls after qualification, the block drops back to its reset hold and re-centres the wiper. It then runs the whole power-up recall again.

The memory cell itself and the analog supply detectors lie outside the block. The settle time and the store time are parameters counted in clock cycles.

Top module: `wiper_nv_seq`

## Requirements
- R1: While reset is high and just after it is released, the wiper code is mid-scale (64 for a 7-bit code), busy is 1, and neither memory strobe is active.
- R2: While the synchronized negative-rail flag is low, the block stays busy with the wiper at mid-scale and issues no memory read, whatever the positive-rail flag does.
- R3: With the negative rail good and the positive rail not good, the block stays busy with the wiper at mid-scale and issues no memory read.
- R4: Once both rails are good, exactly one memory read pulse is issued, and the wiper takes the code the memory returns one cycle after that pulse.
- R5: Busy stays high for exactly SETTLE_CYCLES cycles after the wiper takes the recalled code, and then falls.
- R6: When not busy, a bus write with the persistent flag at 0 loads the wiper on the next clock edge. It issues no memory write, and busy stays low.
- R7: When not busy, a bus write with the persistent flag at 1 loads the wiper and issues one memory write pulse carrying the same code. Busy is then high for exactly STORE_CYCLES cycles, after which the block is ready again.
- R8: While busy, bus writes are ignored: the wiper does not change and no memory write is issued.
- R9: If either rail flag falls after qualification (including during a store), the wiper returns to mid-scale and busy is asserted. When the flags return, a fresh recall loads the stored code.
- R10: The memory read and write strobes are single-cycle pulses and are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| neg_ok | input | 1 | Negative-rail good flag (asynchronous) |
| pos_ok | input | 1 | Positive-rail good flag (asynchronous) |
| bus_we | input | 1 | Wiper write strobe from the bus interface |
| bus_nv | input | 1 | 1: write also stores the code persistently |
| bus_data | input | CODE_W | Code to write |
| mem_rdata | input | CODE_W | Stored code, valid the cycle after a read pulse |
| mem_rd_en | output | 1 | Memory read pulse |
| mem_wr_en | output | 1 | Memory write pulse |
| mem_wdata | output | CODE_W | Code to store |
| wiper_code | output | CODE_W | Current wiper position |
| busy | output | 1 | High in every state except ready; bus locked out |

## Verification
The bench drives the two rail flags in both wrong orders. A design that did not insist on the negative rail first would recall early and show a read pulse while busy should still pin mid-scale. It counts busy cycles exactly across the settle window and the store window, so an off-by-one in the shared down-counter shows up as a wrong cycle count. It injects a persistent write in the middle of a store: a design without the lockout would move the wiper or send a second write that the memory scoreboard rejects. Supply drops are applied both in the ready state and in the middle of a store. A design that ignored them would keep the old code, and one that skipped the re-recall would never bring back the stored value.

// File: rtl/wns_pkg.sv
package wns_pkg;
  typedef enum logic [2:0] {
    ST_RESET_HOLD = 3'd0,
    ST_WAIT_VNEG  = 3'd1,
    ST_WAIT_VCC   = 3'd2,
    ST_RECALL     = 3'd3,
    ST_SETTLE     = 3'd4,
    ST_IDLE       = 3'd5,
    ST_STORE      = 3'd6
  } wns_state_e;
endpackage

// File: rtl/wns_flag_sync.sv
module wns_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES:0] chain;
  assign chain[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i+1] <= 1'b0;
      else     chain[i+1] <= chain[i];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/wns_down_timer.sv
module wns_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/wiper_nv_seq.sv
module wiper_nv_seq #(
  parameter int CODE_W        = 7,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 1000,
  parameter int STORE_CYCLES  = 1200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              neg_ok,
  input  logic              pos_ok,
  input  logic              bus_we,
  input  logic              bus_nv,
  input  logic [CODE_W-1:0] bus_data,
  input  logic [CODE_W-1:0] mem_rdata,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [CODE_W-1:0] mem_wdata,
  output logic [CODE_W-1:0] wiper_code,
  output logic              busy
);
  import wns_pkg::*;

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam int MAX_WAIT = (SETTLE_CYCLES > STORE_CYCLES) ? SETTLE_CYCLES : STORE_CYCLES;
  localparam int TW       = $clog2(MAX_WAIT + 1);
  localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYCLES - 1);
  localparam logic [TW-1:0] STORE_LOAD  = TW'(STORE_CYCLES - 1);

  logic neg_s, pos_s;
  logic t_load, t_zero;
  logic [TW-1:0] t_val;

  wns_state_e        state_q, state_n;
  logic [CODE_W-1:0] wiper_q, wiper_n;
  logic [CODE_W-1:0] wdata_q, wdata_n;
  logic              rd_q, rd_n, wr_q, wr_n;
  logic              rwait_q, rwait_n;
  logic              busy_q;
  logic              rail_lost;

  wns_flag_sync #(.STAGES(SYNC_STAGES)) u_neg_sync (
    .clk(clk), .rst(rst), .d(neg_ok), .q(neg_s)
  );
  wns_flag_sync #(.STAGES(SYNC_STAGES)) u_pos_sync (
    .clk(clk), .rst(rst), .d(pos_ok), .q(pos_s)
  );
  wns_down_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  // Loss of a rail: negative rail counts from WAIT_VCC on, both rails once qualified.
  always_comb begin
    rail_lost = 1'b0;
    case (state_q)
      ST_WAIT_VCC: rail_lost = !neg_s;
      ST_RECALL, ST_SETTLE, ST_IDLE, ST_STORE: rail_lost = !neg_s || !pos_s;
      default: rail_lost = 1'b0;
    endcase
  end

  always_comb begin
    state_n = state_q;
    wiper_n = wiper_q;
    wdata_n = wdata_q;
    rd_n    = 1'b0;
    wr_n    = 1'b0;
    rwait_n = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    if (rail_lost) begin
      state_n = ST_RESET_HOLD;
      wiper_n = MID_CODE;
    end else begin
      case (state_q)
        ST_RESET_HOLD: begin
          wiper_n = MID_CODE;
          state_n = ST_WAIT_VNEG;
        end
        ST_WAIT_VNEG: if (neg_s) state_n = ST_WAIT_VCC;
        ST_WAIT_VCC: if (pos_s) begin
          state_n = ST_RECALL;
          rd_n    = 1'b1;
          rwait_n = 1'b1;
        end
        ST_RECALL: begin
          if (!rwait_q) begin
            wiper_n = mem_rdata;
            state_n = ST_SETTLE;
            t_load  = 1'b1;
            t_val   = SETTLE_LOAD;
          end
        end
        ST_SETTLE: if (t_zero) state_n = ST_IDLE;
        ST_IDLE: if (bus_we) begin
          wiper_n = bus_data;
          if (bus_nv) begin
            wr_n    = 1'b1;
            wdata_n = bus_data;
            state_n = ST_STORE;
            t_load  = 1'b1;
            t_val   = STORE_LOAD;
          end
        end
        ST_STORE: if (t_zero) state_n = ST_IDLE;
        default: state_n = ST_RESET_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RESET_HOLD;
      wiper_q <= MID_CODE;
      wdata_q <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      rwait_q <= 1'b0;
      busy_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      wiper_q <= wiper_n;
      wdata_q <= wdata_n;
      rd_q    <= rd_n;
      wr_q    <= wr_n;
      rwait_q <= rwait_n;
      busy_q  <= (state_n != ST_IDLE);
    end
  end

  assign mem_rd_en  = rd_q;
  assign mem_wr_en  = wr_q;
  assign mem_wdata  = wdata_q;
  assign wiper_code = wiper_q;
  assign busy       = busy_q;
endmodule

// File: rtl/wiper_nv_seq_chk.sv
module wiper_nv_seq_chk #(
  parameter int CODE_W = 7
) (
  input logic                clk,
  input logic                rst,
  input wns_pkg::wns_state_e state,
  input logic                neg_s,
  input logic                pos_s,
  input logic                bus_we,
  input logic [CODE_W-1:0]   bus_data,
  input logic                mem_rd_en,
  input logic                mem_wr_en,
  input logic [CODE_W-1:0]   mem_wdata,
  input logic [CODE_W-1:0]   wiper_code,
  input logic                busy
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R10
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en); // R10
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R10
  AST_VOL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_we && neg_s && pos_s) |=> (wiper_code == $past(bus_data))); // R6
  AST_STORE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (state == wns_pkg::ST_STORE && neg_s && pos_s) |=> $stable(wiper_code)); // R8
  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (busy && wiper_code == mem_wdata)); // R7
  AST_RAIL_DROP: assert property (@(posedge clk) disable iff (rst)
    (!neg_s || !pos_s) |=> (wiper_code == MID && busy)); // R9
endmodule

bind wiper_nv_seq wiper_nv_seq_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .state(state_q), .neg_s(neg_s), .pos_s(pos_s),
  .bus_we(bus_we), .bus_data(bus_data), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .wiper_code(wiper_code),
  .busy(busy)
);

// File: tb/wiper_nv_seq_tb_top.sv
`timescale 1ns/1ps
module wiper_nv_seq_tb_top;
  localparam int CW = 7;
  localparam int SETTLE = 5;
  localparam int STORE = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic neg_ok = 1'b0, pos_ok = 1'b0;
  logic bus_we = 1'b0, bus_nv = 1'b0;
  logic [CW-1:0] bus_data = '0;
  logic [CW-1:0] mem_rdata = '0;
  logic mem_rd_en, mem_wr_en, busy;
  logic [CW-1:0] mem_wdata, wiper_code;

  always #5 clk = ~clk;

  wiper_nv_seq #(.CODE_W(CW), .SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE),
                 .STORE_CYCLES(STORE)) dut_i (
    .clk(clk), .rst(rst), .neg_ok(neg_ok), .pos_ok(pos_ok),
    .bus_we(bus_we), .bus_nv(bus_nv), .bus_data(bus_data),
    .mem_rdata(mem_rdata), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .wiper_code(wiper_code), .busy(busy)
  );

  // Persistent cell model, registered read.
  logic [CW-1:0] nv_cell = 7'h2A;
  always @(posedge clk) begin
    if (mem_wr_en) nv_cell <= mem_wdata;
    if (mem_rd_en) mem_rdata <= nv_cell;
  end

  int n_tests = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;
  bit finished = 0;
  logic [CW-1:0] exp_q[$];
  logic prev_rd = 0, prev_wr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard on memory writes, strobe shape checks (R10).
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) rd_cnt++;
      if (mem_rd_en && mem_wr_en) chk(0, "R10 strobes overlap", 1, 0);
      if (mem_rd_en && prev_rd) chk(0, "R10 read pulse too long", 2, 1);
      if (mem_wr_en && prev_wr) chk(0, "R10 write pulse too long", 2, 1);
      if (mem_wr_en) begin
        wr_cnt++;
        if (exp_q.size() == 0) chk(0, "R8 unexpected memory write", int'(mem_wdata), -1);
        else begin
          logic [CW-1:0] e;
          e = exp_q.pop_front();
          chk(mem_wdata == e, "R7 stored code", int'(mem_wdata), int'(e));
        end
      end
      prev_rd = mem_rd_en;
      prev_wr = mem_wr_en;
    end
  end

  task automatic bus_write(input logic [CW-1:0] d, input bit nv);
    @(negedge clk);
    bus_we = 1'b1; bus_nv = nv; bus_data = d;
    if (nv && !busy) exp_q.push_back(d);
    @(negedge clk);
    bus_we = 1'b0; bus_nv = 1'b0;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (busy && cyc < 300) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int cyc, sc;
    repeat (4) @(negedge clk);
    chk(wiper_code == 64 && busy, "R1 state during reset", int'(wiper_code), 64);
    rst = 1'b0;
    @(negedge clk);
    chk(wiper_code == 64 && busy && !mem_rd_en && !mem_wr_en, "R1 state after reset",
        int'(wiper_code), 64);

    // R2: positive rail good first, negative rail not.
    pos_ok = 1'b1;
    repeat (20) @(negedge clk);
    chk(wiper_code == 64 && busy && rd_cnt == 0, "R2 held without negative rail",
        rd_cnt, 0);

    // R3: negative rail good, positive rail not.
    pos_ok = 1'b0; neg_ok = 1'b1;
    repeat (20) @(negedge clk);
    chk(wiper_code == 64 && busy && rd_cnt == 0, "R3 held without positive rail",
        rd_cnt, 0);

    // R4/R5: both good, recall then settle.
    pos_ok = 1'b1;
    sc = 0; cyc = 0;
    while (busy && cyc < 300) begin
      if (wiper_code == 7'h2A) sc++;
      cyc++;
      @(negedge clk);
    end
    chk(wiper_code == 7'h2A, "R4 recalled code", int'(wiper_code), 'h2A);
    chk(rd_cnt == 1, "R4 one read pulse", rd_cnt, 1);
    chk(sc == SETTLE, "R5 settle cycles", sc, SETTLE);

    // R6: volatile-only write.
    bus_write(7'h11, 1'b0);
    chk(wiper_code == 7'h11 && !busy, "R6 volatile write", int'(wiper_code), 'h11);
    chk(wr_cnt == 0, "R6 no memory write", wr_cnt, 0);

    // R7: persistent write with exact store window.
    @(negedge clk);
    bus_we = 1'b1; bus_nv = 1'b1; bus_data = 7'h55; exp_q.push_back(7'h55);
    @(negedge clk);
    bus_we = 1'b0; bus_nv = 1'b0;
    wait_ready(cyc);
    chk(cyc == STORE, "R7 store busy cycles", cyc, STORE);
    chk(wiper_code == 7'h55 && nv_cell == 7'h55, "R7 wiper and cell", int'(nv_cell), 'h55);
    chk(wr_cnt == 1, "R7 one write pulse", wr_cnt, 1);

    // R8: writes during a store are ignored.
    bus_write(7'h33, 1'b1);
    repeat (2) @(negedge clk);
    bus_write(7'h7F, 1'b1);
    chk(wiper_code == 7'h33, "R8 wiper locked during store", int'(wiper_code), 'h33);
    wait_ready(cyc);
    chk(wiper_code == 7'h33 && wr_cnt == 2, "R8 no extra write", wr_cnt, 2);

    // R9: negative rail lost while ready.
    @(negedge clk); neg_ok = 1'b0;
    repeat (5) @(negedge clk);
    chk(wiper_code == 64 && busy, "R9 drop re-centres", int'(wiper_code), 64);
    neg_ok = 1'b1;
    wait_ready(cyc);
    chk(wiper_code == 7'h33 && rd_cnt == 2, "R9 re-recall", int'(wiper_code), 'h33);

    // R9: positive rail lost during a store.
    bus_write(7'h0C, 1'b1);
    repeat (2) @(negedge clk);
    pos_ok = 1'b0;
    repeat (5) @(negedge clk);
    chk(wiper_code == 64 && busy, "R9 drop during store", int'(wiper_code), 64);
    pos_ok = 1'b1;
    wait_ready(cyc);
    chk(wiper_code == 7'h0C, "R9 recall after store drop", int'(wiper_code), 'h0C);

    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule